// File: doc/BRIEF.md
# Streaming 1D Sliding Window Generator

This block sits in front of a convolution engine and converts a stream of one-dimensional feature-map pixels into the windows (im2col rows) the engine multiplies against its weights. Pixels arrive as packed beats. Each beat holds SIMD channel elements of one pixel. A pixel with C channels therefore takes C/SIMD consecutive beats. For every output position the block replays the K kernel taps of that window across all channels, one SIMD-wide beat at a time. Both ports use a valid/ready handshake, and there is no start or done strobe. An image begins with the first beat after the previous image has been fully consumed.

Shape, kernel, stride, dilation, channel count, lane count and element width are all elaboration-time parameters. The one-dimensional shape may be given as a single row or as a single column; the non-unit axis is the sliding axis either way. A depthwise option changes the interleaving of the output beats so that each channel group's taps come out together. The history is kept in a small ring buffer of `dilation*(K-1)+1+stride` pixels. When that buffer is full, input acceptance stalls until the pending windows have been emitted.

Top module: `swg_window_gen`

## Requirements
- R1: Input and output beats are SIMD*ELEM_W bits wide. Lane i sits in bits [i*ELEM_W +: ELEM_W]. Channel c of a pixel is lane c mod SIMD of fold c/SIMD, and each pixel arrives as C/SIMD beats, fold 0 first.
- R2: Per image the block emits exactly O = floor((L - D*(K-1) - 1)/S) + 1 windows of K*C/SIMD beats each, and no further beat.
- R3: With the depthwise option off, the beats of one window are ordered tap outer and fold inner. Tap k of window o carries input pixel o*S + k*D.
- R4: With the depthwise option on, the beats of one window are ordered fold outer and tap inner, with the same pixel selection as R3.
- R5: With dilation D > 1, consecutive taps of a window are D pixels apart.
- R6: A shape given as L rows by one column produces the same window stream as one row by L columns.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data holds its value. out_valid only falls after a completed transfer.
- R8: If no output beat is accepted, the block takes exactly D*(K-1)+1+S pixels and then holds in_ready low.
- R9: Once all L pixels of an image are taken and all of its windows issued, the block returns to its initial state. Trailing pixels that no window uses are still consumed, and the next image's windows contain only that image's pixels.
- R10: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts the input beat |
| in_data | input | SIMD*ELEM_W | Packed lanes of one channel fold of one pixel |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer accepts the output beat |
| out_data | output | SIMD*ELEM_W | Packed lanes of one tap and fold of a window |

## Verification
The bench checks every output beat against a window model. Each input element encodes its pixel, fold and lane, so any of the following faults shows up as a wrong value: a swapped tap and fold order, a wrong tap spacing under dilation, or a stride applied on the wrong axis. A consumer that holds ready low for a long stretch checks two things. First, the fill limit: a buffer one pixel too deep or too shallow changes the accepted count. Second, the output hold: a design that advances while stalled drops or repeats beats. Back-to-back images and a shape with an unused trailing pixel check the restart. A design that keeps counters or stale pixels, or stops short of consuming the tail, stalls or emits the previous image's data.

// File: rtl/swg_pkg.sv
package swg_pkg;

   // Beat interleaving inside one window.
   typedef enum logic {
      ORDER_TAP_MAJOR  = 1'b0,
      ORDER_FOLD_MAJOR = 1'b1
   } beat_order_e;

   // Number of windows over an unpadded line.
   function automatic int win_count(int len, int ker, int stride, int dil);
      return (len - dil * (ker - 1) - 1) / stride + 1;
   endfunction

   // Pixels the ring buffer must hold: one window span plus one stride step.
   function automatic int ring_pixels(int ker, int stride, int dil);
      return dil * (ker - 1) + 1 + stride;
   endfunction

endpackage

// File: rtl/swg_store.sv
module swg_store #(
   parameter int BEAT_W = 16,
   parameter int WORDS  = 8,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BEAT_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [BEAT_W-1:0] rd_data
);

   logic [BEAT_W-1:0] mem_q [WORDS];

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[wr_addr] <= wr_data;
   end

   assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/swg_writer.sv
module swg_writer #(
   parameter int FOLDS   = 2,
   parameter int LEN     = 10,
   parameter int BUF_PIX = 4,
   parameter int PIX_W   = 5,
   parameter int SLOT_W  = 2,
   parameter int FOLD_W  = 1,
   parameter int ADDR_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [PIX_W-1:0]  rd_lo,
   input  logic              rd_done,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [PIX_W-1:0]  wr_pix
);

   logic [PIX_W-1:0]  pix_q;
   logic [FOLD_W-1:0] fold_q;
   logic [SLOT_W-1:0] slot_q;
   logic              room;
   logic              fold_last;

   // A pixel may enter only if it cannot overwrite one still needed by the
   // oldest pending window; once all windows are out, the tail drains freely.
   assign room      = rd_done || (pix_q < rd_lo + PIX_W'(BUF_PIX));
   assign in_ready  = (pix_q < PIX_W'(LEN)) && room;
   assign wr_en     = in_valid && in_ready;
   assign fold_last = (fold_q == FOLD_W'(FOLDS - 1));
   assign wr_addr   = ADDR_W'(slot_q) * ADDR_W'(FOLDS) + ADDR_W'(fold_q);
   assign wr_pix    = pix_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_q  <= '0;
         fold_q <= '0;
         slot_q <= '0;
      end else if (clear) begin
         pix_q  <= '0;
         fold_q <= '0;
         slot_q <= '0;
      end else if (wr_en) begin
         if (fold_last) begin
            fold_q <= '0;
            pix_q  <= pix_q + PIX_W'(1);
            slot_q <= (slot_q == SLOT_W'(BUF_PIX - 1)) ? '0 : slot_q + SLOT_W'(1);
         end else begin
            fold_q <= fold_q + FOLD_W'(1);
         end
      end
   end

   // R8: the writer never runs more than the ring depth ahead of the reader
   a_r8_buffer_bound : assert property (@(posedge clk) disable iff (!rst_n)
      !rd_done |-> (pix_q <= rd_lo + PIX_W'(BUF_PIX)));

endmodule

// File: rtl/swg_reader.sv
module swg_reader #(
   parameter int BEAT_W     = 16,
   parameter int FOLDS      = 2,
   parameter int KER        = 3,
   parameter int STRIDE     = 1,
   parameter int DIL        = 1,
   parameter int SPAN       = 3,
   parameter int BUF_PIX    = 4,
   parameter int WINS       = 8,
   parameter int PIX_W      = 5,
   parameter int SLOT_W     = 2,
   parameter int FOLD_W     = 1,
   parameter int TAP_W      = 2,
   parameter int WIN_W      = 4,
   parameter int ADDR_W     = 3,
   parameter bit FOLD_MAJOR = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic [PIX_W-1:0]  wr_pix,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [BEAT_W-1:0] rd_word,
   output logic [PIX_W-1:0]  rd_lo,
   output logic              rd_done,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [BEAT_W-1:0] out_data
);

   logic [WIN_W-1:0]  win_q;
   logic [PIX_W-1:0]  lo_q;
   logic [SLOT_W-1:0] base_q;
   logic [TAP_W-1:0]  tap_q, tap_n;
   logic [FOLD_W-1:0] fold_q, fold_n;
   logic              ov_q;
   logic [BEAT_W-1:0] od_q;

   logic              avail, issue;
   logic              tap_last, fold_last, win_last;
   logic [SLOT_W:0]   tap_sum, base_sum;
   logic [SLOT_W-1:0] tap_slot, base_n;

   assign rd_done   = (win_q == WIN_W'(WINS));
   assign rd_lo     = lo_q;
   assign avail     = !rd_done && (wr_pix >= lo_q + PIX_W'(SPAN));
   assign issue     = avail && (!ov_q || out_ready);
   assign tap_last  = (tap_q == TAP_W'(KER - 1));
   assign fold_last = (fold_q == FOLD_W'(FOLDS - 1));
   assign win_last  = tap_last && fold_last;

   // Ring slot of the tap: window base plus tap*dilation, wrapped once.
   assign tap_sum  = {1'b0, base_q} + (SLOT_W + 1)'(tap_q) * (SLOT_W + 1)'(DIL);
   assign tap_slot = (tap_sum >= (SLOT_W + 1)'(BUF_PIX))
                     ? SLOT_W'(tap_sum - (SLOT_W + 1)'(BUF_PIX)) : SLOT_W'(tap_sum);
   assign base_sum = {1'b0, base_q} + (SLOT_W + 1)'(STRIDE);
   assign base_n   = (base_sum >= (SLOT_W + 1)'(BUF_PIX))
                     ? SLOT_W'(base_sum - (SLOT_W + 1)'(BUF_PIX)) : SLOT_W'(base_sum);
   assign rd_addr  = ADDR_W'(tap_slot) * ADDR_W'(FOLDS) + ADDR_W'(fold_q);

   // Interleaving variant: which counter is the inner loop.
   generate
      if (FOLD_MAJOR) begin : g_fold_major
         always_comb begin
            if (tap_last) begin
               tap_n  = '0;
               fold_n = fold_last ? '0 : fold_q + FOLD_W'(1);
            end else begin
               tap_n  = tap_q + TAP_W'(1);
               fold_n = fold_q;
            end
         end
      end else begin : g_tap_major
         always_comb begin
            if (fold_last) begin
               fold_n = '0;
               tap_n  = tap_last ? '0 : tap_q + TAP_W'(1);
            end else begin
               fold_n = fold_q + FOLD_W'(1);
               tap_n  = tap_q;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q  <= '0;
         lo_q   <= '0;
         base_q <= '0;
         tap_q  <= '0;
         fold_q <= '0;
         ov_q   <= 1'b0;
         od_q   <= '0;
      end else begin
         if (issue) begin
            od_q   <= rd_word;
            ov_q   <= 1'b1;
            tap_q  <= tap_n;
            fold_q <= fold_n;
            if (win_last) begin
               win_q  <= win_q + WIN_W'(1);
               lo_q   <= lo_q + PIX_W'(STRIDE);
               base_q <= base_n;
            end
         end else if (out_ready) begin
            ov_q <= 1'b0;
         end
         if (clear) begin
            win_q  <= '0;
            lo_q   <= '0;
            base_q <= '0;
            tap_q  <= '0;
            fold_q <= '0;
         end
      end
   end

   assign out_valid = ov_q;
   assign out_data  = od_q;

   // R7: a stalled beat stays put
   a_r7_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (ov_q && !out_ready) |=> (ov_q && $stable(od_q)));

   // R7: a beat only disappears after the consumer took it
   a_r7_no_drop : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ov_q) |-> $past(out_ready));

endmodule

// File: rtl/swg_window_gen.sv
module swg_window_gen
   import swg_pkg::*;
#(
   parameter int ELEM_W    = 8,
   parameter int CH        = 4,
   parameter int SIMD      = 2,
   parameter int IMG_H     = 1,
   parameter int IMG_W     = 10,
   parameter int KER_H     = 1,
   parameter int KER_W     = 3,
   parameter int STR_H     = 1,
   parameter int STR_W     = 1,
   parameter int DIL_H     = 1,
   parameter int DIL_W     = 1,
   parameter bit DEPTHWISE = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [SIMD*ELEM_W-1:0] in_data,
   output logic                   out_valid,
   input  logic                   out_ready,
   output logic [SIMD*ELEM_W-1:0] out_data
);

   // The unit axis contributes a factor of one, so products give the line.
   localparam int LEN     = IMG_H * IMG_W;
   localparam int KER     = KER_H * KER_W;
   localparam int STRIDE  = STR_H * STR_W;
   localparam int DIL     = DIL_H * DIL_W;
   localparam int FOLDS   = CH / SIMD;
   localparam int BEAT_W  = SIMD * ELEM_W;
   localparam int SPAN    = DIL * (KER - 1) + 1;
   localparam int BUF_PIX = ring_pixels(KER, STRIDE, DIL);
   localparam int WINS    = win_count(LEN, KER, STRIDE, DIL);
   localparam int WORDS   = BUF_PIX * FOLDS;
   localparam int PIX_W   = $clog2(LEN + BUF_PIX + STRIDE + 1) + 1;
   localparam int SLOT_W  = $clog2(BUF_PIX);
   localparam int FOLD_W  = (FOLDS > 1) ? $clog2(FOLDS) : 1;
   localparam int TAP_W   = (KER > 1) ? $clog2(KER) : 1;
   localparam int WIN_W   = $clog2(WINS + 1);
   localparam int ADDR_W  = $clog2(WORDS);
   localparam beat_order_e ORDER = DEPTHWISE ? ORDER_FOLD_MAJOR : ORDER_TAP_MAJOR;

   // Elaboration-time parameter checks.
   generate
      if (CH % SIMD != 0) begin : g_bad_lanes
         $error("channel count must be a multiple of the lane count");
      end
      if (IMG_H != 1 && IMG_W != 1) begin : g_bad_shape
         $error("one image dimension must be 1");
      end
      if (IMG_H == 1) begin : g_axis_w
         if (KER_H != 1 || STR_H != 1 || DIL_H != 1) begin : g_bad_unit
            $error("kernel, stride and dilation must be 1 on the unit axis");
         end
      end else begin : g_axis_h
         if (KER_W != 1 || STR_W != 1 || DIL_W != 1) begin : g_bad_unit
            $error("kernel, stride and dilation must be 1 on the unit axis");
         end
      end
      if (DIL > 1 && STRIDE > 1) begin : g_bad_combo
         $error("dilation above 1 cannot be combined with stride above 1");
      end
      if (SPAN > LEN) begin : g_bad_span
         $error("dilated kernel span exceeds the line length");
      end
   endgenerate

   logic              clear;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr, rd_addr;
   logic [PIX_W-1:0]  wr_pix, rd_lo;
   logic              rd_done;
   logic [BEAT_W-1:0] rd_word;

   // Image boundary: every pixel taken and every window issued.
   assign clear = (wr_pix == PIX_W'(LEN)) && rd_done;

   swg_writer #(
      .FOLDS(FOLDS), .LEN(LEN), .BUF_PIX(BUF_PIX), .PIX_W(PIX_W),
      .SLOT_W(SLOT_W), .FOLD_W(FOLD_W), .ADDR_W(ADDR_W)
   ) u_writer (
      .clk(clk), .rst_n(rst_n), .clear(clear),
      .in_valid(in_valid), .in_ready(in_ready),
      .rd_lo(rd_lo), .rd_done(rd_done),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_pix(wr_pix)
   );

   swg_store #(
      .BEAT_W(BEAT_W), .WORDS(WORDS), .ADDR_W(ADDR_W)
   ) u_store (
      .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(in_data),
      .rd_addr(rd_addr), .rd_data(rd_word)
   );

   swg_reader #(
      .BEAT_W(BEAT_W), .FOLDS(FOLDS), .KER(KER), .STRIDE(STRIDE), .DIL(DIL),
      .SPAN(SPAN), .BUF_PIX(BUF_PIX), .WINS(WINS), .PIX_W(PIX_W),
      .SLOT_W(SLOT_W), .FOLD_W(FOLD_W), .TAP_W(TAP_W), .WIN_W(WIN_W),
      .ADDR_W(ADDR_W), .FOLD_MAJOR(ORDER == ORDER_FOLD_MAJOR)
   ) u_reader (
      .clk(clk), .rst_n(rst_n), .clear(clear),
      .wr_pix(wr_pix), .rd_addr(rd_addr), .rd_word(rd_word),
      .rd_lo(rd_lo), .rd_done(rd_done),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

   // R9: an image boundary returns both sides to their initial state
   a_r9_restart : assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_pix == PIX_W'(LEN)) && rd_done) |=> ((wr_pix == '0) && !rd_done && (rd_lo == '0)));

endmodule

// File: tb/tb_swg_window_gen.sv
`timescale 1ns/1ps
module tb_swg_window_gen;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        in_valid  [3];
   logic        in_ready  [3];
   logic [15:0] in_data   [3];
   logic        out_valid [3];
   logic        out_ready [3];
   logic [15:0] out_data  [3];

   int n_checks = 0;
   int n_fail   = 0;

   // Normal order, width axis, K=3, S=1, D=1, L=10
   swg_window_gen #(.ELEM_W(8), .CH(4), .SIMD(2), .IMG_H(1), .IMG_W(10),
      .KER_H(1), .KER_W(3), .STR_H(1), .STR_W(1), .DIL_H(1), .DIL_W(1),
      .DEPTHWISE(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid[0]), .in_ready(in_ready[0]),
      .in_data(in_data[0]), .out_valid(out_valid[0]), .out_ready(out_ready[0]),
      .out_data(out_data[0]));

   // Depthwise order, height axis, K=3, S=2, L=10 (one unused trailing pixel)
   swg_window_gen #(.ELEM_W(8), .CH(4), .SIMD(2), .IMG_H(10), .IMG_W(1),
      .KER_H(3), .KER_W(1), .STR_H(2), .STR_W(1), .DIL_H(1), .DIL_W(1),
      .DEPTHWISE(1'b1)) dut_dw (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid[1]), .in_ready(in_ready[1]),
      .in_data(in_data[1]), .out_valid(out_valid[1]), .out_ready(out_ready[1]),
      .out_data(out_data[1]));

   // Dilated, width axis, K=3, D=2, S=1, L=10
   swg_window_gen #(.ELEM_W(8), .CH(4), .SIMD(2), .IMG_H(1), .IMG_W(10),
      .KER_H(1), .KER_W(3), .STR_H(1), .STR_W(1), .DIL_H(1), .DIL_W(2),
      .DEPTHWISE(1'b0)) dut_dil (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid[2]), .in_ready(in_ready[2]),
      .in_data(in_data[2]), .out_valid(out_valid[2]), .out_ready(out_ready[2]),
      .out_data(out_data[2]));

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // Element value encodes pixel, fold and lane: salt + 4*pixel + channel
   function automatic logic [15:0] pix_beat(int salt, int p, int f);
      logic [15:0] b;
      for (int l = 0; l < 2; l++) b[l*8 +: 8] = 8'(salt + p * 4 + f * 2 + l);
      return b;
   endfunction

   // One image through one instance, producer and checking consumer in parallel.
   task automatic run_image(int idx, int salt, int L, int K, int S, int D, bit dw,
                            int gap, int rmode, int hold, int hold_exp, string req);
      int nwin  = (L - D * (K - 1) - 1) / S + 1;
      int total = nwin * K * 2;
      int acc   = 0;
      int got   = 0;
      fork
         begin : producer
            int p = 0;
            int f = 0;
            int cyc = 0;
            while (p < L) begin
               @(negedge clk);
               in_valid[idx] = (gap == 0) || (cyc % gap != 0);
               in_data[idx]  = pix_beat(salt, p, f);
               #1;
               if (in_valid[idx] && in_ready[idx]) begin
                  acc++;
                  f++;
                  if (f == 2) begin f = 0; p++; end
               end
               cyc++;
            end
            @(negedge clk);
            in_valid[idx] = 1'b0;
         end
         begin : consumer
            int o = 0;
            int j = 0;
            int cyc = 0;
            bit stalled = 1'b0;
            logic [15:0] held = '0;
            while (got < total && cyc < 5000) begin
               @(negedge clk);
               if (stalled)
                  chk(out_valid[idx] && out_data[idx] == held, "R7", "stalled beat held",
                      int'(out_data[idx]), int'(held));
               if (hold > 0 && cyc == hold)
                  chk(acc == hold_exp, "R8", "beats accepted with output blocked", acc, hold_exp);
               if (cyc < hold)          out_ready[idx] = 1'b0;
               else if (rmode == 0)     out_ready[idx] = 1'b1;
               else if (rmode == 1)     out_ready[idx] = (cyc % 3 != 0);
               else                     out_ready[idx] = (cyc % 5 < 2);
               #1;
               if (out_valid[idx] && out_ready[idx]) begin
                  int k = dw ? (j % K) : (j / 2);
                  int f = dw ? (j / K) : (j % 2);
                  logic [15:0] e = pix_beat(salt, o * S + k * D, f);
                  chk(out_data[idx] == e, req, $sformatf("window %0d tap %0d fold %0d", o, k, f),
                      int'(out_data[idx]), int'(e));
                  got++;
                  j++;
                  if (j == 2 * K) begin j = 0; o++; end
                  stalled = 1'b0;
               end else begin
                  stalled = out_valid[idx];
                  held    = out_data[idx];
               end
               cyc++;
            end
            @(negedge clk);
            out_ready[idx] = 1'b1;
         end
      join
      chk(got == total, "R2", "beats per image", got, total);
      repeat (20) @(negedge clk);
      chk(!out_valid[idx], "R2", "no beat after last window", int'(out_valid[idx]), 0);
      chk(in_ready[idx], "R9", "ready for next image", int'(in_ready[idx]), 1);
   endtask

   task automatic t_reset;
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
         chk(!out_valid[i], "R10", "out_valid after reset", int'(out_valid[i]), 0);
         chk(in_ready[i], "R10", "in_ready after reset", int'(in_ready[i]), 1);
      end
   endtask

   task automatic t_tap_major;
      run_image(0, 0, 10, 3, 1, 1, 1'b0, 0, 0, 0, 0, "R1/R3");
   endtask

   task automatic t_back_to_back;
      // second image with gaps and a choppy consumer: no stale pixels
      run_image(0, 100, 10, 3, 1, 1, 1'b0, 3, 1, 0, 0, "R9/R3");
   endtask

   task automatic t_backpressure;
      // span 3 plus stride 1 -> 4 pixels = 8 beats before in_ready drops
      run_image(0, 50, 10, 3, 1, 1, 1'b0, 0, 0, 40, 8, "R8/R3");
   endtask

   task automatic t_fold_major;
      run_image(1, 20, 10, 3, 2, 1, 1'b1, 0, 2, 0, 0, "R4/R6");
      run_image(1, 140, 10, 3, 2, 1, 1'b1, 2, 0, 0, 0, "R4/R9");
   endtask

   task automatic t_dilated;
      run_image(2, 30, 10, 3, 1, 2, 1'b0, 0, 1, 0, 0, "R5");
      run_image(2, 60, 10, 3, 1, 2, 1'b0, 0, 0, 30, 12, "R5/R8");
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < 3; i++) begin
         in_valid[i]  = 1'b0;
         in_data[i]   = '0;
         out_ready[i] = 1'b1;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_tap_major();
      t_back_to_back();
      t_backpressure();
      t_fold_major();
      t_dilated();
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule